// File: doc/BRIEF.md
# Two-Window Shadowed Overlay Register Bank

This block keeps the configuration of two overlay windows in a display pipeline. Every window field exists twice: a pending copy that the register write port fills, and an active copy that the scan-out logic reads. Writes only ever land in the pending copy. The pending copy moves into the active copy on a vsync pulse, and only for a window that has an outstanding update request and is not protected. All eight fields of that window move in the same clock edge.

Software follows a fixed sequence. It sets the protect bit of a window, rewrites any number of that window's fields, raises the update request, and clears the protect bit. The scan-out side therefore never sees a partly written set of values. A request that meets a protected window waits, and it is served at the first vsync after protection is lifted. A small state machine per window (IDLE, ARMED, HELD) tracks whether a request is outstanding and whether it may be served.

Top module: `shadow_bank`

Write address map (5 bits, with the default two windows):
- Addresses 0 to 15 are per-window fields. Address bit 3 selects the window, and bits 2:0 select the field.
- Field codes: 0 = buffer start, 1 = whole width including padding, 2 = whole height, 3 = X offset, 4 = Y offset, 5 = top-left corner, 6 = bottom-right corner, 7 = control. Bit 0 of the control field is the window enable.
- Address 16 is the protect mask. Data bit w protects window w.
- Address 17 is the update request. Writing with data bit 0 set requests an update for every window.

Active field f of window w sits at `act_regs[(w*8+f)*32 +: 32]`.

Per-window states and transitions:
- IDLE (no request). It goes to ARMED on an update write while the window is unprotected, or to HELD on an update write while it is protected.
- ARMED (request outstanding, unprotected). It goes to HELD when protect is set. It goes to IDLE when a vsync transfers the window and no update write arrives in that same cycle. If an update write does arrive in that cycle, it stays ARMED.
- HELD (request outstanding, protected). It never transfers. It goes to ARMED when protect is cleared.

## Requirements
- R1: After reset all active fields are zero, both windows are disabled, no update request is outstanding and no window is protected.
- R2: A write to field f of window w changes only the pending copy. The active outputs do not change until a transfer.
- R3: A write to address 17 with data bit 0 set makes `upd_busy` high for every window from the next cycle. A write there with bit 0 clear has no effect.
- R4: On a vsync cycle, a window with an outstanding request and a clear protect bit copies all eight pending fields to its active copy. The new values are visible in the cycle after the vsync, and the window's request clears at the same point.
- R5: While bit w of the protect mask is set, vsync does not transfer window w, and its request stays outstanding.
- R6: After the protect bit of a window with an outstanding request is cleared, the next vsync transfers the held values.
- R7: A vsync with no outstanding request for a window leaves that window's active copy unchanged.
- R8: When a field write and a transfer of the same window fall in one cycle, the transfer carries the old pending value, and the new value waits for a later transfer.
- R9: An update write in the same cycle as a transfer leaves the request outstanding after that transfer.
- R10: Clearing the enable bit (control field bit 0) changes `win_enable` only at the transfer, never at the write.
- R11: Protect bits act per window. Protecting one window does not stop a transfer of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (see map) |
| wr_data | input | 32 | Write data |
| vsync | input | 1 | One-cycle vertical sync pulse |
| act_regs | output | 512 | Active field copies of both windows, flattened |
| win_enable | output | 2 | Active enable bit per window |
| upd_busy | output | 2 | Update request outstanding per window |

## Verification
Some behaviour is checked by the assertions on every cycle:
- Active values and enables change only in the cycle after an unprotected vsync.
- An update write always raises the outstanding flags.
- A served request clears unless a new one coincides.
- A protected window keeps its request.

Other behaviour only the bench scenarios can show, because it needs the bench's own model of the pending contents:
- That the transferred values equal the last pending writes.
- That a write coinciding with vsync is deferred.
- That a request held by protection is served after unprotecting.
- That the enable clear is delayed to the transfer.

// File: rtl/shadow_bank_pkg.sv
`timescale 1ns/1ps
package shadow_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } win_state_e;

    typedef enum logic [2:0] {
        FLD_BASE    = 3'd0,
        FLD_WHOLE_W = 3'd1,
        FLD_WHOLE_H = 3'd2,
        FLD_OFF_X   = 3'd3,
        FLD_OFF_Y   = 3'd4,
        FLD_TOPLEFT = 3'd5,
        FLD_BOTRITE = 3'd6,
        FLD_CTRL    = 3'd7
    } field_e;

    localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/shadow_win_ctrl.sv
`timescale 1ns/1ps
module shadow_win_ctrl
    import shadow_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic upd_wr,
    input  logic prot_d,
    output logic xfer,
    output logic busy
);

    win_state_e state_q, state_d;
    logic       req_next;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        req_next = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_next = upd_wr;
            end
            ST_ARMED: begin
                req_next = !vsync || upd_wr;
            end
            ST_HELD: begin
                req_next = 1'b1;
            end
            default: begin
                req_next = 1'b0;
            end
        endcase
        if (!req_next)   state_d = ST_IDLE;
        else if (prot_d) state_d = ST_HELD;
        else             state_d = ST_ARMED;
    end

    always_comb begin
        xfer = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin xfer = 1'b0;  busy = 1'b0; end
            ST_ARMED: begin xfer = vsync; busy = 1'b1; end
            ST_HELD:  begin xfer = 1'b0;  busy = 1'b1; end
            default:  begin xfer = 1'b0;  busy = 1'b0; end
        endcase
    end

endmodule

// File: rtl/shadow_win_regs.sv
`timescale 1ns/1ps
module shadow_win_regs #(
    parameter int DATA_W  = 32,
    parameter int NFIELD  = 8,
    parameter int FIELD_W = $clog2(NFIELD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_sel,
    input  logic [FIELD_W-1:0]       wr_field,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     xfer,
    output logic [NFIELD*DATA_W-1:0] act_flat
);

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        logic [DATA_W-1:0] pend_q;
        logic [DATA_W-1:0] act_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else if (wr_sel && wr_field == FIELD_W'(f)) begin
                pend_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    act_q <= '0;
            else if (xfer) act_q <= pend_q;
        end

        assign act_flat[f*DATA_W +: DATA_W] = act_q;
    end

endmodule

// File: rtl/shadow_bank.sv
`timescale 1ns/1ps
module shadow_bank
    import shadow_bank_pkg::*;
#(
    parameter int  NWIN    = 2,
    parameter int  DATA_W  = 32,
    parameter int  NFIELD  = 8,
    localparam int FIELD_W = $clog2(NFIELD),
    localparam int WIN_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int ADDR_W  = FIELD_W + WIN_W + 1,
    localparam int ACT_W   = NWIN * NFIELD * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vsync,
    output logic [ACT_W-1:0]  act_regs,
    output logic [NWIN-1:0]   win_enable,
    output logic [NWIN-1:0]   upd_busy
);

    localparam int LOW_W      = FIELD_W + WIN_W;
    localparam int GADDR_PROT = 0;
    localparam int GADDR_UPD  = 1;

    logic            glob_sel;
    logic            prot_wr;
    logic            upd_wr;
    logic [NWIN-1:0] prot_q;
    logic [NWIN-1:0] prot_d;
    logic [NWIN-1:0] xfer;

    assign glob_sel = wr_en && wr_addr[ADDR_W-1];
    assign prot_wr  = glob_sel && (wr_addr[LOW_W-1:0] == LOW_W'(GADDR_PROT));
    assign upd_wr   = glob_sel && (wr_addr[LOW_W-1:0] == LOW_W'(GADDR_UPD)) && wr_data[0];
    assign prot_d   = prot_wr ? wr_data[NWIN-1:0] : prot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= '0;
        else        prot_q <= prot_d;
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic wr_sel;

        assign wr_sel = wr_en && !wr_addr[ADDR_W-1]
                        && (wr_addr[FIELD_W +: WIN_W] == WIN_W'(w));

        shadow_win_ctrl i_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .vsync  (vsync),
            .upd_wr (upd_wr),
            .prot_d (prot_d[w]),
            .xfer   (xfer[w]),
            .busy   (upd_busy[w])
        );

        shadow_win_regs #(
            .DATA_W  (DATA_W),
            .NFIELD  (NFIELD)
        ) i_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel),
            .wr_field (wr_addr[FIELD_W-1:0]),
            .wr_data  (wr_data),
            .xfer     (xfer[w]),
            .act_flat (act_regs[w*NFIELD*DATA_W +: NFIELD*DATA_W])
        );

        assign win_enable[w] =
            act_regs[(w*NFIELD + int'(FLD_CTRL))*DATA_W + CTRL_EN_BIT];
    end

endmodule

// File: rtl/shadow_bank_chk.sv
`timescale 1ns/1ps
module shadow_bank_chk #(
    parameter int NWIN   = 2,
    parameter int DATA_W = 32,
    parameter int NFIELD = 8,
    parameter int ADDR_W = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic                          vsync,
    input logic [NWIN*NFIELD*DATA_W-1:0] act_regs,
    input logic [NWIN-1:0]               win_enable,
    input logic [NWIN-1:0]               upd_busy,
    input logic [NWIN-1:0]               prot_q
);

    localparam int WBITS = NFIELD * DATA_W;

    logic upd_now;
    assign upd_now = wr_enable_upd(wr_en, wr_addr, wr_data);

    function automatic logic wr_enable_upd(input logic en, input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
        return en && (a == ADDR_W'((1 << (ADDR_W-1)) + 1)) && d[0];
    endfunction

    for (genvar w = 0; w < NWIN; w++) begin : g_chk
        AST_ACT_ONLY_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
            (act_regs[w*WBITS +: WBITS] != $past(act_regs[w*WBITS +: WBITS]))
            |-> ($past(vsync) && !$past(prot_q[w]) && $past(upd_busy[w])))
            else $error("act changed off vsync"); // R4

        AST_ENABLE_AT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(vsync) |-> $stable(win_enable[w]))
            else $error("enable moved without vsync"); // R10

        AST_UPD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            upd_now |=> upd_busy[w])
            else $error("update write did not arm"); // R3

        AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (vsync && upd_busy[w] && !prot_q[w] && !upd_now) |=> !upd_busy[w])
            else $error("served request not cleared"); // R4

        AST_PROT_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_busy[w] && prot_q[w]) |=> upd_busy[w])
            else $error("protected request dropped"); // R5

        AST_NO_REQ_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
            (vsync && !upd_busy[w]) |=> $stable(act_regs[w*WBITS +: WBITS]))
            else $error("transfer without request"); // R7
    end

endmodule

bind shadow_bank shadow_bank_chk #(
    .NWIN   (NWIN),
    .DATA_W (DATA_W),
    .NFIELD (NFIELD),
    .ADDR_W (ADDR_W)
) i_shadow_bank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .vsync      (vsync),
    .act_regs   (act_regs),
    .win_enable (win_enable),
    .upd_busy   (upd_busy),
    .prot_q     (prot_q)
);

// File: tb/test_shadow_bank.sv
`timescale 1ns/1ps
module test_shadow_bank;

    localparam int NWIN = 2, DATA_W = 32, NFIELD = 8, ADDR_W = 5;
    localparam int ACT_W = NWIN*NFIELD*DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              vsync = 1'b0;
    logic [ACT_W-1:0]  act_regs;
    logic [NWIN-1:0]   win_enable;
    logic [NWIN-1:0]   upd_busy;

    shadow_bank i_shadow_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vsync(vsync), .act_regs(act_regs),
        .win_enable(win_enable), .upd_busy(upd_busy)
    );

    always #4 clk = ~clk;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [DATA_W-1:0] m_pend [NWIN][NFIELD];
    logic [DATA_W-1:0] m_act  [NWIN][NFIELD];
    logic [NWIN-1:0]   m_req, m_prot;

    function automatic logic [ACT_W-1:0] exp_act();
        logic [ACT_W-1:0] v;
        for (int w = 0; w < NWIN; w++)
            for (int f = 0; f < NFIELD; f++)
                v[(w*NFIELD+f)*DATA_W +: DATA_W] = m_act[w][f];
        return v;
    endfunction

    function automatic logic [NWIN-1:0] exp_en();
        logic [NWIN-1:0] e;
        for (int w = 0; w < NWIN; w++) e[w] = m_act[w][7][0];
        return e;
    endfunction

    task automatic check(input string tag, input logic [ACT_W-1:0] got_a, input logic [ACT_W-1:0] exp_a,
                         input logic [NWIN-1:0] got_b, input logic [NWIN-1:0] exp_b,
                         input logic [NWIN-1:0] got_e, input logic [NWIN-1:0] exp_e);
        checks++;
        if (got_a !== exp_a || got_b !== exp_b || got_e !== exp_e) begin
            errors++;
            $display("FAIL %s: act=%h busy=%b en=%b expected act=%h busy=%b en=%b",
                     tag, got_a, got_b, got_e, exp_a, exp_b, exp_e);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, act_regs, exp_act(), upd_busy, m_req, win_enable, exp_en());
    endtask

    // Drive one cycle (called at negedge), update model, sample at next negedge.
    task automatic step(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic vs);
        logic [NWIN-1:0] xf;
        logic upd;
        wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
        xf  = {NWIN{vs}} & m_req & ~m_prot;
        upd = we && a == 5'd17 && d[0];
        for (int w = 0; w < NWIN; w++)
            if (xf[w]) for (int f = 0; f < NFIELD; f++) m_act[w][f] = m_pend[w][f];
        if (we && !a[4]) m_pend[a[3]][a[2:0]] = d;
        if (we && a == 5'd16) m_prot = d[NWIN-1:0];
        m_req = (m_req & ~xf) | {NWIN{upd}};
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
    endtask

    task automatic idle(); step(1'b0, '0, '0, 1'b0); endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] saved;
        void'($urandom(32'h1f2e3d4c));
        for (int w = 0; w < NWIN; w++)
            for (int f = 0; f < NFIELD; f++) begin m_pend[w][f] = '0; m_act[w][f] = '0; end
        m_req = '0; m_prot = '0;
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R2 / R7: fill window 0 pending, vsync without request
        for (int f = 0; f < NFIELD; f++) wr(5'(f), 32'hA000_0000 + f);
        check_all("R2 pending only");
        step(1'b0, '0, '0, 1'b1);
        check_all("R7 vsync without request");

        // R3: update request with bit0 clear has no effect, then set
        wr(5'd17, 32'h0);
        check_all("R3 update bit clear ignored");
        wr(5'd17, 32'h1);
        check_all("R3 update arms both windows");
        step(1'b0, '0, '0, 1'b1);
        check_all("R4 transfer and request clear");

        // R5 / R11: protect window 1, update both
        wr(5'd16, 32'h2);
        for (int f = 0; f < NFIELD; f++) wr(5'(8+f), 32'hB100_0000 + f);
        wr(5'd1, 32'h0000_0123);
        wr(5'd17, 32'h1);
        step(1'b0, '0, '0, 1'b1);
        check_all("R5 protected window held, R11 window 0 moved");
        step(1'b0, '0, '0, 1'b1);
        check_all("R5 request still pending");

        // R6: unprotect, next vsync transfers held set
        wr(5'd16, 32'h0);
        check_all("R6 unprotect alone no transfer");
        step(1'b0, '0, '0, 1'b1);
        check_all("R6 held values transferred");

        // R8: write coinciding with transfer
        wr(5'd17, 32'h1);
        saved = m_pend[0][2];
        step(1'b1, 5'd2, 32'hDEAD_0002, 1'b1);
        check_all("R8 old pending transferred");
        if (m_act[0][2] !== saved) begin errors++; $display("FAIL R8 model: act=%h expected=%h", m_act[0][2], saved); end
        checks++;
        wr(5'd17, 32'h1);
        step(1'b0, '0, '0, 1'b1);
        check_all("R8 new value on following vsync");

        // R9: update write with transfer keeps request
        wr(5'd17, 32'h1);
        step(1'b1, 5'd17, 32'h1, 1'b1);
        check_all("R9 request survives coincident update");
        step(1'b0, '0, '0, 1'b1);
        check_all("R9 served afterwards");

        // R10: enable clear deferred to transfer
        wr(5'd15, 32'h1);
        wr(5'd17, 32'h1);
        step(1'b0, '0, '0, 1'b1);
        check_all("R10 enable set at transfer");
        wr(5'd15, 32'h0);
        wr(5'd17, 32'h1);
        check_all("R10 enable kept until vsync");
        step(1'b0, '0, '0, 1'b1);
        check_all("R10 enable cleared at vsync");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [ADDR_W-1:0] a;
            logic we;
            r  = $urandom;
            we = (r[2:0] != 3'd0);
            case (r[5:3])
                3'd0:    a = 5'd16;
                3'd1:    a = 5'd17;
                default: a = 5'(r[9:6]);
            endcase
            step(we, a, (a == 5'd16) ? 32'(r[11:10]) : $urandom, (r[15:13] == 3'd0));
            check_all("R4 random compare");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule